// File: doc/BRIEF.md
# Serial Four-Channel Converter Register Front End

This block takes 16-bit command frames from a three-wire serial link and turns them into register writes for a four-channel output converter. The link has an active-low frame-sync level, a serial clock and a data line. All three are brought into the system clock domain through two-flop synchronisers. Bits are taken on the falling edge of the serial clock, most significant bit first. A frame counts only when sixteen falling edges arrive while sync stays low. If sync rises sooner, the partial frame is dropped and nothing is written. Once the sixteenth bit is in, the receiver locks. Any further clock and data activity is ignored until sync goes high and then low again.

Each accepted frame writes the input register of the channel it addresses. It also sets the global power-down flag. A per-frame update bit chooses between two actions. One writes the input register only. The other also copies all four input registers into the output registers in the same cycle. The output registers drive the four converter codes. The output-enable signal is the inverse of the power-down flag.

The resolution is set by a parameter of 8, 10 or 12 bits. The data field is always bits 11:0, and the low bits that the resolution does not reach are discarded. The serial clock must run slower than a quarter of the system clock rate.

Top module: `qdac_serial_front`

## Requirements
- R1: A frame is accepted after 16 falling serial-clock edges seen while fsync_n is low. Bits are taken MSB first. Acceptance gives a one-cycle frame_done pulse. The outputs change only in the cycle after a frame_done pulse.
- R2: Bits 15:14 select the channel: 00 is A, 01 is B, 10 is C and 11 is D. Only the addressed channel's input register takes the frame's data code.
- R3: When bit 12 is 1, no output code changes.
- R4: When bit 12 is 0, all four output codes take the contents of their input registers in the same cycle. The addressed register's new code is included. This happens in the cycle after frame_done.
- R5: Every accepted frame updates power_dn from bit 13. Bit 13 = 0 gives power_dn=1 and out_en=0. Bit 13 = 1 gives power_dn=0 and out_en=1.
- R6: If fsync_n rises after 1 to 15 falling edges, the block gives a one-cycle frame_abort pulse. No register, output code or power_dn changes.
- R7: After the 16th edge, further serial-clock edges are ignored until fsync_n goes high and then low again. The later rise of fsync_n gives no abort, and no second frame_done is produced.
- R8: For DATA_W below 12, the code is frame bits 11 down to 12-DATA_W, and the lower bits are ignored. For example, with DATA_W=8 the frame code 0x00F gives the output code 0x00.
- R9: After reset, all codes are 0, power_dn=1, out_en=0, and no pulse is present.
- R10: frame_done and frame_abort are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous |
| fsync_n | input | 1 | Active-low frame-sync level, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| code_a | output | DATA_W | Output-register code of channel A |
| code_b | output | DATA_W | Output-register code of channel B |
| code_c | output | DATA_W | Output-register code of channel C |
| code_d | output | DATA_W | Output-register code of channel D |
| power_dn | output | 1 | Global power-down flag |
| out_en | output | 1 | Output drive enable, low means high impedance |
| frame_done | output | 1 | One-cycle pulse for an accepted frame |
| frame_abort | output | 1 | One-cycle pulse for a discarded partial frame |

## Verification
A bit counter that is off by one, or that has lost its lock, shows at the ports within one frame. It gives a missing or extra frame_done, or a spurious frame_abort when fsync_n rises. It can also shift the code so that it lands in the wrong channel. The input-register stage cannot be seen directly. A wrong value there shows up only at the next frame with bit 12 at 0, when all four codes are copied at once. For this reason, each sequence of input-only writes is followed by such a frame, and all four codes are compared against a model in the cycle after frame_done.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int FRAME_W = 16;
   localparam int CH_N    = 4;
   localparam int SEL_W   = 2;
   localparam int FIELD_W = 12;

   typedef struct packed {
      logic [SEL_W-1:0]   chan;
      logic               run;
      logic               hold;
      logic [FIELD_W-1:0] code;
   } frame_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
   import qdac_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sclk_s,
   input  logic   fsync_n_s,
   input  logic   din_s,
   output logic   done,
   output logic   abort,
   output frame_t word
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic               sclk_d;
   logic               fall;
   logic               locked;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] shnext;

   assign fall   = sclk_d & ~sclk_s;
   assign shnext = {shreg[FRAME_W-2:0], din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         locked <= 1'b0;
         cnt    <= '0;
         shreg  <= '0;
         word   <= '0;
         done   <= 1'b0;
         abort  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         done   <= 1'b0;
         abort  <= 1'b0;
         if (fsync_n_s) begin
            if (cnt != '0 && !locked)
               abort <= 1'b1;
            cnt    <= '0;
            locked <= 1'b0;
         end else if (!locked && fall) begin
            shreg <= shnext;
            if (cnt == LAST) begin
               word   <= frame_t'(shnext);
               done   <= 1'b1;
               locked <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
   import qdac_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     done,
   input  frame_t                   word,
   output logic [CH_N*DATA_W-1:0]   in_flat,
   output logic [CH_N*DATA_W-1:0]   out_flat,
   output logic                     power_dn
);
   localparam int DROP_W = FIELD_W - DATA_W;

   logic [DATA_W-1:0] code_new;
   logic [DATA_W-1:0] in_q  [CH_N];
   logic [DATA_W-1:0] out_q [CH_N];

   generate
      if (DROP_W == 0) begin : g_full
         assign code_new = word.code;
      end else begin : g_trim
         logic [DROP_W-1:0] unused_lsb;
         assign code_new   = word.code[FIELD_W-1 -: DATA_W];
         assign unused_lsb = word.code[DROP_W-1:0];
      end
   endgenerate

   generate
      for (genvar i = 0; i < CH_N; i++) begin : g_ch
         logic sel;
         assign sel = (word.chan == SEL_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_q[i]  <= '0;
               out_q[i] <= '0;
            end else if (done) begin
               if (sel)
                  in_q[i] <= code_new;
               if (!word.hold)
                  out_q[i] <= sel ? code_new : in_q[i];
            end
         end

         assign in_flat[i*DATA_W +: DATA_W]  = in_q[i];
         assign out_flat[i*DATA_W +: DATA_W] = out_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         power_dn <= 1'b1;
      else if (done)
         power_dn <= ~word.run;
   end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
   import qdac_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              fsync_n,
   input  logic              sdin,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic [DATA_W-1:0] code_c,
   output logic [DATA_W-1:0] code_d,
   output logic              power_dn,
   output logic              out_en,
   output logic              frame_done,
   output logic              frame_abort
);
   generate
      if (DATA_W != 8 && DATA_W != 10 && DATA_W != 12) begin : g_bad_width
         $error("qdac_serial_front: DATA_W must be 8, 10 or 12");
      end
   endgenerate

   logic [2:0]               raw_in;
   logic [2:0]               sync_out;
   frame_t                   rx_word;
   logic [CH_N*DATA_W-1:0]   in_flat;
   logic [CH_N*DATA_W-1:0]   out_flat;

   assign raw_in = {fsync_n, sclk, sdin};

   qdac_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   qdac_frame_rx u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sync_out[1]),
      .fsync_n_s (sync_out[2]),
      .din_s     (sync_out[0]),
      .done      (frame_done),
      .abort     (frame_abort),
      .word      (rx_word)
   );

   qdac_regbank #(.DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (frame_done),
      .word     (rx_word),
      .in_flat  (in_flat),
      .out_flat (out_flat),
      .power_dn (power_dn)
   );

   assign code_a = out_flat[0*DATA_W +: DATA_W];
   assign code_b = out_flat[1*DATA_W +: DATA_W];
   assign code_c = out_flat[2*DATA_W +: DATA_W];
   assign code_d = out_flat[3*DATA_W +: DATA_W];
   assign out_en = ~power_dn;
endmodule

// File: rtl/qdac_serial_checker.sv
module qdac_serial_checker #(
   parameter int DATA_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  done,
   input logic                  abort,
   input logic [15:0]           word,
   input logic [4*DATA_W-1:0]   codes,
   input logic [4*DATA_W-1:0]   in_flat,
   input logic                  power_dn,
   input logic                  out_en
);
   logic [DATA_W-1:0] fcode;
   assign fcode = word[11 -: DATA_W];

   a_r10_done_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && abort));

   a_r1_quiet_without_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(codes) && $stable(power_dn) && $stable(in_flat)));

   a_r3_hold_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (done && word[12]) |=> $stable(codes));

   a_r6_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> ($stable(codes) && $stable(in_flat) && $stable(power_dn)));

   a_r5_pd_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (power_dn == !$past(word[13])));

   a_r5_enable_opposes_pd: assert property (@(posedge clk) disable iff (!rst_n)
      out_en != power_dn);

   generate
      for (genvar i = 0; i < 4; i++) begin : g_r4
         a_r4_addressed_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !word[12] && word[15:14] == 2'(i))
            |=> codes[i*DATA_W +: DATA_W] == $past(fcode));
         a_r2_input_write: assert property (@(posedge clk) disable iff (!rst_n)
            (done && word[15:14] == 2'(i))
            |=> in_flat[i*DATA_W +: DATA_W] == $past(fcode));
      end
   endgenerate
endmodule

bind qdac_serial_front qdac_serial_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (frame_done),
   .abort    (frame_abort),
   .word     (rx_word),
   .codes    ({code_d, code_c, code_b, code_a}),
   .in_flat  (in_flat),
   .power_dn (power_dn),
   .out_en   (out_en)
);

// File: tb/qdac_serial_front_bench.sv
module qdac_serial_front_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1;
   logic fsync_n = 1'b1;
   logic sdin = 1'b0;

   logic [11:0] ca, cb, cc, cd;
   logic [7:0]  na, nb, nc, nd;
   logic pd, oe, done, abrt, pd8, oe8, done8, abrt8;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   typedef struct {
      bit         is_abort;
      logic [11:0] codes [4];
      logic       pd;
      string      tag;
   } item_t;

   item_t sb [$];
   logic [11:0] in_m  [4];
   logic [11:0] out_m [4];
   logic        pd_m;

   always #5 clk = ~clk;

   qdac_serial_front #(.DATA_W(12)) u_qdac_serial_front (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
      .code_a(ca), .code_b(cb), .code_c(cc), .code_d(cd),
      .power_dn(pd), .out_en(oe), .frame_done(done), .frame_abort(abrt));

   qdac_serial_front #(.DATA_W(8)) u_qdac_serial_front_w8 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
      .code_a(na), .code_b(nb), .code_c(nc), .code_d(nd),
      .power_dn(pd8), .out_en(oe8), .frame_done(done8), .frame_abort(abrt8));

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("[TB] FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(bit ab, string tag);
      item_t it;
      it.is_abort = ab;
      for (int i = 0; i < 4; i++) it.codes[i] = out_m[i];
      it.pd  = pd_m;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // Send nbits of word; when nbits == 16, extra further clocks follow.
   task automatic send(logic [15:0] w, int nbits, int extra, string tag);
      if (nbits == 16) begin
         in_m[w[15:14]] = w[11:0];
         if (!w[12]) for (int i = 0; i < 4; i++) out_m[i] = in_m[i];
         pd_m = ~w[13];
         push(1'b0, tag);
      end else begin
         push(1'b1, tag);
      end
      fsync_n = 1'b0;
      wait_cyc(4);
      for (int b = 0; b < nbits + extra; b++) begin
         sdin = (b < nbits) ? w[15-b] : 1'b1;
         sclk = 1'b1;
         wait_cyc(4);
         sclk = 1'b0;
         wait_cyc(4);
      end
      sclk = 1'b1;
      wait_cyc(4);
      fsync_n = 1'b1;
      wait_cyc(10);
   endtask

   function automatic logic [15:0] mk(logic [1:0] ch, logic run, logic hold, logic [11:0] code);
      return {ch, run, hold, code};
   endfunction

   // Monitor: pops the scoreboard on every pulse, compares outputs one cycle later.
   always @(negedge clk) begin
      if (rst_n && (done || abrt)) begin
         item_t it;
         check("R10", "pulse overlap", {31'd0, done && abrt}, 32'd0);
         check("R8", "narrow instance pulse", {30'd0, done8, abrt8}, {30'd0, done, abrt});
         if (sb.size() == 0) begin
            tests++;
            fails++;
            $display("[TB] FAIL R7 unexpected pulse actual=%0d%0d expected=none", done, abrt);
         end else begin
            it = sb.pop_front();
            check(it.tag, "pulse kind", {31'd0, abrt}, {31'd0, it.is_abort});
            @(negedge clk);
            check(it.tag, "code_a", {20'd0, ca}, {20'd0, it.codes[0]});
            check(it.tag, "code_b", {20'd0, cb}, {20'd0, it.codes[1]});
            check(it.tag, "code_c", {20'd0, cc}, {20'd0, it.codes[2]});
            check(it.tag, "code_d", {20'd0, cd}, {20'd0, it.codes[3]});
            check(it.tag, "power_dn", {31'd0, pd}, {31'd0, it.pd});
            check(it.tag, "out_en", {31'd0, oe}, {31'd0, ~it.pd});
            check("R8", "narrow codes", {na, nb, nc, nd},
                  {it.codes[0][11:4], it.codes[1][11:4], it.codes[2][11:4], it.codes[3][11:4]});
         end
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin in_m[i] = '0; out_m[i] = '0; end
      pd_m = 1'b1;
      wait_cyc(3);
      // R9 reset state
      check("R9", "codes after reset", {ca, cb, cc, cd}, 48'd0);
      check("R9", "pd/oe/pulses after reset", {28'd0, pd, oe, done, abrt}, {28'd0, 4'b1000});
      rst_n = 1'b1;
      wait_cyc(5);
      check("R9", "held after release", {28'd0, pd, oe, done, abrt}, {28'd0, 4'b1000});

      send(mk(2'b00, 1'b1, 1'b1, 12'hABC), 16, 0, "R3");
      send(mk(2'b01, 1'b1, 1'b1, 12'h123), 16, 0, "R2");
      send(mk(2'b10, 1'b1, 1'b1, 12'h456), 16, 0, "R2");
      send(mk(2'b11, 1'b1, 1'b0, 12'h789), 16, 0, "R4");
      send(mk(2'b00, 1'b1, 1'b1, 12'hFFF), 16, 0, "R3");
      send(mk(2'b01, 1'b1, 1'b0, 12'hEEE), 7, 0, "R6");
      send(mk(2'b01, 1'b1, 1'b0, 12'h00F), 16, 0, "R8");
      send(mk(2'b10, 1'b1, 1'b0, 12'h5A5), 16, 5, "R7");
      send(mk(2'b11, 1'b0, 1'b1, 12'h333), 16, 0, "R5");
      send(mk(2'b00, 1'b1, 1'b0, 12'h111), 15, 0, "R6");
      send(mk(2'b10, 1'b1, 1'b0, 12'h222), 1, 0, "R6");
      send(mk(2'b11, 1'b1, 1'b0, 12'hC3C), 16, 0, "R1");
      send(mk(2'b00, 1'b0, 1'b0, 12'h0F0), 16, 0, "R5");

      wait_cyc(10);
      check("R1", "scoreboard drained", sb.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         tests++;
         fails++;
         $display("[TB] FAIL watchdog actual=%0d expected<100000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule